// File: doc/BRIEF.md
# GF(2^233) Karatsuba Multiplier with Trinomial Reduction

This block multiplies two elements of the binary field GF(2^233) held in polynomial basis and returns their product reduced modulo x^233 + x^74 + 1. Each operand is cut into a low part (bits 116..0) and a high part (bits 232..117). Three half-size carry-less products are formed: low by low, high by high, and the XOR-sum of the two parts of one operand by the XOR-sum of the two parts of the other. These products are recombined into a 465-bit unreduced product with XOR only, and that product is folded back to 233 bits by a word-oriented shift-and-XOR reduction on 32-bit words.

The whole datapath is combinational between the operand ports and a single result register. A caller presents both operands with a one-cycle valid strobe. The reduced product and a matching valid strobe appear on the next clock. A new operand pair may be issued every cycle. When no strobe is given, the result register keeps its last value.

Top module: `gf233_kara_mul`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0 and out_prod is all zeros.
- R2: out_valid is high in exactly those cycles that directly follow a cycle in which in_valid was sampled high at a rising clock edge. Each strobe yields exactly one result, in issue order, and back-to-back strobes are accepted.
- R3: The result presented with out_valid equals the carry-less product of op_a and op_b reduced modulo x^233 + x^74 + 1. Bit i of each port is the coefficient of x^i.
- R4: When either operand is zero, the result is zero.
- R5: When either operand is the constant 1 (only bit 0 set), the result equals the other operand.
- R6: The result does not depend on operand order: op_a·op_b equals op_b·op_a.
- R7: In a cycle with in_valid low, the operands are ignored. out_prod keeps its previous value and out_valid is 0 in the following cycle.
- R8: Overflow past degree 232 is folded back through the trinomial. Multiplying x^232 by x yields x^74 + 1 (bits 74 and 0 set, all others clear). All-ones operands give the reduced square of the all-ones polynomial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; op_a and op_b are taken at this rising edge |
| op_a | input | 233 | First field operand, bit i = coefficient of x^i |
| op_b | input | 233 | Second field operand, bit i = coefficient of x^i |
| out_valid | output | 1 | High for one cycle per accepted operand pair |
| out_prod | output | 233 | Reduced product; held between strobes |

## Verification
Every product is due exactly one clock after the rising edge that samples its in_valid strobe. The bench drives operands on the falling edge and samples out_valid and out_prod on a later falling edge, half a period after the result register loads. A driver computes each expected product with a bit-serial shift-and-reduce model and queues it when it issues the strobe. A monitor then pops one entry for every cycle out_valid is seen high, so results that are missing, surplus or out of order show up as mismatches. The hold behaviour is checked on the falling edges of idle cycles that follow a result, while the operands are being changed.

// File: rtl/gf233_pkg.sv
package gf233_pkg;
    localparam int FIELD_W  = 233;
    localparam int PROD_W   = 2 * FIELD_W - 1;
    localparam int WORD_W   = 32;
    localparam int FWORDS   = (FIELD_W + WORD_W - 1) / WORD_W;
    localparam int PWORDS   = 2 * FWORDS;
    localparam int PAD_W    = PWORDS * WORD_W;
    localparam int TOP_BITS = FIELD_W - (FWORDS - 1) * WORD_W;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [PROD_W-1:0]  prod_t;

    typedef struct packed {
        logic   vld;
        field_t res;
    } state_t;
endpackage

// File: rtl/gf2_clmul.sv
module gf2_clmul #(
    parameter int AW = 117,
    parameter int BW = 117,
    localparam int PW = AW + BW - 1
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [PW-1:0] p
);
    logic [PW-1:0] a_ext;

    assign a_ext = PW'(a);

    always_comb begin
        p = '0;
        for (int i = 0; i < BW; i++) begin
            if (b[i]) begin
                p = p ^ (a_ext << i);
            end
        end
    end
endmodule

// File: rtl/gf2_kara_split.sv
module gf2_kara_split #(
    parameter int FW = 233,
    localparam int LW = (FW + 1) / 2,
    localparam int HW = FW - LW,
    localparam int PW = 2 * FW - 1
) (
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    output logic [PW-1:0] p
);
    logic [LW-1:0]     a_lo, b_lo, a_sum, b_sum;
    logic [HW-1:0]     a_hi, b_hi;
    logic [2*LW-2:0]   pr_lo, pr_mid, mid_term;
    logic [2*HW-2:0]   pr_hi;

    assign a_lo  = a[LW-1:0];
    assign b_lo  = b[LW-1:0];
    assign a_hi  = a[FW-1:LW];
    assign b_hi  = b[FW-1:LW];

    // half-sums of each operand
    assign a_sum = a_lo ^ LW'(a_hi);
    assign b_sum = b_lo ^ LW'(b_hi);

    gf2_clmul #(.AW(LW), .BW(LW)) u_lo  (.a(a_lo),  .b(b_lo),  .p(pr_lo));
    gf2_clmul #(.AW(HW), .BW(HW)) u_hi  (.a(a_hi),  .b(b_hi),  .p(pr_hi));
    gf2_clmul #(.AW(LW), .BW(LW)) u_mid (.a(a_sum), .b(b_sum), .p(pr_mid));

    // middle coefficient: cross term with both outer products removed
    assign mid_term = pr_mid ^ pr_lo ^ (2*LW-1)'(pr_hi);

    // assemble the double-width product
    assign p = PW'(pr_lo) ^ (PW'(mid_term) << LW) ^ (PW'(pr_hi) << (2 * LW));
endmodule

// File: rtl/gf233_fold.sv
module gf233_fold
    import gf233_pkg::*;
(
    input  prod_t  wide,
    output field_t narrow
);
    // fold offsets on 32-bit words for x^233 = x^74 + 1
    localparam int SH_A = 23;
    localparam int SH_B = 9;
    localparam int SH_C = 1;
    localparam int SH_D = 31;
    localparam int SH_E = 10;
    localparam int SH_F = 22;

    always_comb begin
        logic [PAD_W-1:0]  flat;
        logic [WORD_W-1:0] w [PWORDS];
        logic [WORD_W-1:0] t;
        flat = PAD_W'(wide);
        for (int k = 0; k < PWORDS; k++) begin
            w[k] = flat[k*WORD_W +: WORD_W];
        end
        for (int i = PWORDS - 1; i >= FWORDS; i--) begin
            t          = w[i];
            w[i-8] = w[i-8] ^ (t << SH_A);
            w[i-7] = w[i-7] ^ (t >> SH_B);
            w[i-5] = w[i-5] ^ (t << SH_C);
            w[i-4] = w[i-4] ^ (t >> SH_D);
        end
        t     = w[FWORDS-1] >> TOP_BITS;
        w[0]  = w[0] ^ t;
        w[2]  = w[2] ^ (t << SH_E);
        w[3]  = w[3] ^ (t >> SH_F);
        w[FWORDS-1] = w[FWORDS-1] & WORD_W'((1 << TOP_BITS) - 1);
        for (int k = 0; k < FWORDS; k++) begin
            flat[k*WORD_W +: WORD_W] = w[k];
        end
        narrow = flat[FIELD_W-1:0];
    end
endmodule

// File: rtl/gf233_kara_mul.sv
module gf233_kara_mul
    import gf233_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] op_a,
    input  logic [FIELD_W-1:0] op_b,
    output logic               out_valid,
    output logic [FIELD_W-1:0] out_prod
);
    prod_t  raw_prod;
    field_t red_prod;
    state_t st_d, st_q;

    gf2_kara_split #(.FW(FIELD_W)) u_split (
        .a (op_a),
        .b (op_b),
        .p (raw_prod)
    );

    gf233_fold u_fold (
        .wide   (raw_prod),
        .narrow (red_prod)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = red_prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_prod  = st_q.res;
endmodule

// File: rtl/gf233_kara_mul_chk.sv
module gf233_kara_mul_chk
    import gf233_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [FIELD_W-1:0] op_a,
    input logic [FIELD_W-1:0] op_b,
    input logic               out_valid,
    input logic [FIELD_W-1:0] out_prod
);
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod));

    p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a == '0 || op_b == '0)) |=> (out_prod == '0));

    p_unit_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == FIELD_W'(1)) |=> (out_prod == $past(op_b)));
endmodule

bind gf233_kara_mul gf233_kara_mul_chk chk_i (.*);

// File: tb/gf233_kara_mul_tb.sv
module gf233_kara_mul_tb_top;
    localparam int  CLK_P = 10;
    localparam int  FW    = 233;
    localparam int  WDOG  = 20000;

    typedef struct {
        logic [FW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] op_a = '0;
    logic [FW-1:0] op_b = '0;
    logic          out_valid;
    logic [FW-1:0] out_prod;

    int     n_tests = 0;
    int     n_fail  = 0;
    bit     done    = 1'b0;
    item_t  sb_q [$];
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_P/2) clk = ~clk;

    gf233_kara_mul dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // bit-serial reference: Horner scheme with reduction each step
    function automatic logic [FW-1:0] ref_mul(input logic [FW-1:0] a, input logic [FW-1:0] b);
        logic [FW:0] r;
        r = '0;
        for (int i = FW - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[FW]) begin
                r[FW] = 1'b0;
                r[74] = ~r[74];
                r[0]  = ~r[0];
            end
            if (b[i]) r = r ^ {1'b0, a};
        end
        return r[FW-1:0];
    endfunction

    task automatic draw(output logic [FW-1:0] v);
        logic [255:0] acc;
        acc = '0;
        for (int k = 0; k < 4; k++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            acc = {acc[191:0], rng};
        end
        v = acc[FW-1:0];
    endtask

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [FW-1:0] a, input logic [FW-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        in_valid = 1'b1;
        it.exp   = ref_mul(a, b);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // R7: operands without strobe must leave the result untouched
    task automatic hold_check;
        logic [FW-1:0] snap;
        logic [FW-1:0] junk;
        @(negedge clk);
        snap     = out_prod;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            draw(junk);
            op_a = junk;
            op_b = ~junk;
            @(negedge clk);
            check("R7 hold out_prod", out_prod, snap);
            check("R7 out_valid low", {{(FW-1){1'b0}}, out_valid}, '0);
        end
    endtask

    // monitor: one scoreboard entry per valid result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R2: actual out_valid 1 expected 0 (no pending item)");
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, out_prod, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_P * WDOG);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [FW-1:0] a, b, ones, x232, x1;
        ones = '1;
        x232 = '0; x232[232] = 1'b1;
        x1   = '0; x1[1]     = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_prod in reset", out_prod, '0);
        check("R1 out_valid in reset", {{(FW-1){1'b0}}, out_valid}, '0);
        rst_n = 1'b1;
        idle(2);

        // R4 / R5 corner operands
        draw(a);
        send('0, a, "R4 zero*a");
        send(a, '0, "R4 a*zero");
        send(FW'(1), a, "R5 one*a");
        send(a, FW'(1), "R5 a*one");
        idle(2);
        hold_check();

        // R8: overflow folding and all-ones
        send(x232, x1, "R8 x^232*x");
        idle(1);
        check("R8 x^232*x literal", out_prod, (FW'(1) << 74) | FW'(1));
        send(ones, ones, "R8 ones*ones");
        send(x232, x232, "R8 x^232*x^232");
        idle(2);
        hold_check();

        // R3 / R6: random pairs, back to back, both orders
        for (int n = 0; n < 20; n++) begin
            draw(a);
            draw(b);
            send(a, b, "R3 random a*b");
            send(b, a, "R6 commuted b*a");
        end
        // R3 sparse patterns with gaps between strobes
        for (int n = 0; n < 8; n++) begin
            draw(a);
            b = '0;
            b[n * 29] = 1'b1;
            send(a, b, "R3 a*monomial");
            idle(1);
        end
        idle(3);

        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: actual %0d pending results expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule